// File: doc/BRIEF.md
# Sprite Attribute Block Copy Engine

This engine fills the sprite attribute RAM from a 256-byte-aligned page anywhere in the address space. The processor starts a copy by writing a page number to a trigger input. The engine waits a fixed start-up time and then moves one byte on each machine-cycle enable. It reads the byte through an external read port and writes it through a sprite RAM write port in the same clock. The transfer length is 160 bytes by default.

While a copy is in flight, the engine raises `active` and presents its current source address. The bus decoder uses these two signals to lock the processor out of the regions that the copy touches. The engine's own reads go straight to the read port and are not subject to that lockout. Arbitration with the video engine lies outside this block.

The controller has three states: `ST_IDLE`, `ST_WARMUP` and `ST_COPY`. The transitions are:
- *launch*: `ST_IDLE` to `ST_WARMUP` on an accepted trigger.
- *restart*: `ST_WARMUP` or `ST_COPY` to `ST_WARMUP` on an accepted trigger.
- *warm*: `ST_WARMUP` to `ST_COPY` when the start-up count expires.
- *finish*: `ST_COPY` to `ST_IDLE` on the tick that moves the final byte.

Top module: `spr_dma_engine`

## Requirements
- R1: A trigger with page P ≤ 0xF1 (MAX_PAGE) is accepted. From the next clock, `active` is 1, `src_addr` equals {P, 8'h00}, the destination is offset 0, and XFER_LEN bytes are left to move.
- R2: A trigger with page P > 0xF1 is ignored. An idle engine stays idle with no writes. A running copy carries on from the same source with the same count.
- R3: The first byte moves on the START_DELAY_MC-th tick of `mcyc_en` after an accepted trigger (default 2, which is 8 clocks at one tick per 4 clocks). Each later byte moves on the next tick.
- R4: On each move, `rd_en` and `spr_we` are 1 together. `spr_wdata` equals `rd_data`, read from `src_addr`. After the move, `src_addr` is one higher.
- R5: An uninterrupted copy writes exactly XFER_LEN bytes, to sprite offsets 0, 1, … XFER_LEN-1 in that order.
- R6: An accepted trigger while a copy is running abandons that copy. The engine restarts from the new page at offset 0, with the full count and a fresh start-up delay. If the trigger lands on a tick, no byte moves on that clock.
- R7: `active` is 0 after reset. It rises on the clock after an accepted trigger and falls on the clock after the final byte moves.
- R8: `done` is 1 for exactly the one clock in which the final byte is written, and at no other time.
- R9: `spr_we` and `rd_en` are never 1 on a clock where `mcyc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcyc_en | input | 1 | Machine-cycle tick, one clock wide |
| trig_wr | input | 1 | Processor write strobe to the trigger register |
| trig_page | input | PAGE_W | Source page (high address byte) |
| rd_en | output | 1 | Read strobe of the source read port |
| src_addr | output | ADDR_W | Current source address: read-port address and lockout address |
| rd_data | input | DATA_W | Byte returned combinationally for `src_addr` |
| spr_we | output | 1 | Sprite RAM write enable |
| spr_addr | output | SPR_AW | Sprite RAM write offset |
| spr_wdata | output | DATA_W | Sprite RAM write data |
| active | output | 1 | Copy in flight; drives the bus lockout |
| done | output | 1 | One-clock pulse with the final byte write |

## Verification
A wrong internal count shows directly at the ports. A wrong start-up counter moves the first write away from its tick. A wrong destination or source counter shows on the very next write as an offset that does not match the source's low byte, or as a data byte that does not match the source address. A wrong remaining count shows at the end of the copy: `done` or the fall of `active` comes early or late, or the number of writes is wrong. Restart and reject errors show within one tick of the trigger, as a write from the old page or a missing write.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WARMUP = 2'd1,
        ST_COPY   = 2'd2
    } dma_state_e;
endpackage

// File: rtl/spr_dma_trig_check.sv
module spr_dma_trig_check #(
    parameter int PAGE_W   = 8,
    parameter int MAX_PAGE = 'hF1
) (
    input  logic              trig_wr,
    input  logic [PAGE_W-1:0] trig_page,
    output logic              accept
);
    // pages above the limit never launch a copy
    assign accept = trig_wr && (trig_page <= PAGE_W'(MAX_PAGE));
endmodule

// File: rtl/spr_dma_warmup.sv
module spr_dma_warmup #(
    parameter int START_DELAY_MC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int DW = $clog2(START_DELAY_MC + 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= DW'(START_DELAY_MC - 1);
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // leaving warm-up on this tick puts the first move on the following tick
    assign expire = run && tick && !load && (cnt_q == DW'(1));
endmodule

// File: rtl/spr_dma_addr_gen.sv
module spr_dma_addr_gen #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 8,
    parameter int SPR_AW   = 8,
    parameter int XFER_LEN = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              step,
    output logic [ADDR_W-1:0] src_addr,
    output logic [SPR_AW-1:0] dst_addr,
    output logic [$clog2(XFER_LEN+1)-1:0] remaining
);
    localparam int LOW_W = ADDR_W - PAGE_W;
    localparam int CNT_W = $clog2(XFER_LEN + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr  <= '0;
            dst_addr  <= '0;
            remaining <= '0;
        end else if (load) begin
            src_addr  <= {load_page, {LOW_W{1'b0}}};
            dst_addr  <= '0;
            remaining <= CNT_W'(XFER_LEN);
        end else if (step) begin
            src_addr  <= src_addr + 1'b1;
            dst_addr  <= dst_addr + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end
endmodule

// File: rtl/spr_dma_engine.sv
module spr_dma_engine
    import spr_dma_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int PAGE_W         = 8,
    parameter int SPR_AW         = 8,
    parameter int DATA_W         = 8,
    parameter int XFER_LEN       = 160,
    parameter int START_DELAY_MC = 2,
    parameter int MAX_PAGE       = 'hF1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mcyc_en,
    input  logic              trig_wr,
    input  logic [PAGE_W-1:0] trig_page,
    output logic              rd_en,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              spr_we,
    output logic [SPR_AW-1:0] spr_addr,
    output logic [DATA_W-1:0] spr_wdata,
    output logic              active,
    output logic              done
);
    localparam int CNT_W = $clog2(XFER_LEN + 1);

    dma_state_e       state_q, state_d;
    logic             accept;
    logic             expire;
    logic             step;
    logic             last;
    logic [CNT_W-1:0] remaining;
    logic [SPR_AW-1:0] dst_addr;

    spr_dma_trig_check #(
        .PAGE_W   (PAGE_W),
        .MAX_PAGE (MAX_PAGE)
    ) u_trig (
        .trig_wr   (trig_wr),
        .trig_page (trig_page),
        .accept    (accept)
    );

    spr_dma_warmup #(
        .START_DELAY_MC (START_DELAY_MC)
    ) u_warm (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .run    (state_q == ST_WARMUP),
        .tick   (mcyc_en),
        .expire (expire)
    );

    spr_dma_addr_gen #(
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W),
        .SPR_AW   (SPR_AW),
        .XFER_LEN (XFER_LEN)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_page (trig_page),
        .step      (step),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .remaining (remaining)
    );

    // an accepted trigger always wins over a move on the same clock
    assign step = (state_q == ST_COPY) && mcyc_en && !accept;
    assign last = (remaining == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_WARMUP;                 // launch
            end
            ST_WARMUP: begin
                if (accept)      state_d = ST_WARMUP;            // restart
                else if (expire) state_d = ST_COPY;              // warm
            end
            ST_COPY: begin
                if (accept)           state_d = ST_WARMUP;       // restart
                else if (step && last) state_d = ST_IDLE;        // finish
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_en     = step;
        spr_we    = step;
        spr_addr  = dst_addr;
        spr_wdata = rd_data;
        active    = (state_q != ST_IDLE);
        done      = step && last;
    end
endmodule

// File: rtl/spr_dma_engine_chk.sv
module spr_dma_engine_chk #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 8,
    parameter int SPR_AW   = 8,
    parameter int CNT_W    = 8,
    parameter int MAX_PAGE = 'hF1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mcyc_en,
    input logic              trig_wr,
    input logic [PAGE_W-1:0] trig_page,
    input logic [ADDR_W-1:0] src_addr,
    input logic              spr_we,
    input logic [SPR_AW-1:0] spr_addr,
    input logic              active,
    input logic              done,
    input logic [CNT_W-1:0]  remaining
);
    localparam int LOW_W = ADDR_W - PAGE_W;

    a_r1_accept_load: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && trig_page <= PAGE_W'(MAX_PAGE)) |=>
            (active && src_addr == {$past(trig_page), {LOW_W{1'b0}}}));

    a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && trig_wr && trig_page > PAGE_W'(MAX_PAGE)) |=> !active);

    a_r4_src_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && !trig_wr) |=> (src_addr == $past(src_addr) + 1'b1));

    a_r5_dst_follows_src: assert property (@(posedge clk) disable iff (!rst_n)
        spr_we |-> (spr_addr == src_addr[SPR_AW-1:0]));

    a_r7_active_count: assert property (@(posedge clk) disable iff (!rst_n)
        active == (remaining != '0));

    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !trig_wr) |=> !active);

    a_r8_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spr_we);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        spr_we |-> mcyc_en);
endmodule

bind spr_dma_engine spr_dma_engine_chk #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .SPR_AW   (SPR_AW),
    .CNT_W    (CNT_W),
    .MAX_PAGE (MAX_PAGE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mcyc_en   (mcyc_en),
    .trig_wr   (trig_wr),
    .trig_page (trig_page),
    .src_addr  (src_addr),
    .spr_we    (spr_we),
    .spr_addr  (spr_addr),
    .active    (active),
    .done      (done),
    .remaining (remaining)
);

// File: tb/spr_dma_engine_test.sv
`timescale 1ns/1ps
module spr_dma_engine_test;
    localparam int LEN   = 16;
    localparam int START = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  phase = 2'd0;
    logic        mcyc_en;
    logic        trig_wr = 1'b0;
    logic [7:0]  trig_page = 8'h00;
    logic        rd_en;
    logic [15:0] src_addr;
    logic [7:0]  rd_data;
    logic        spr_we;
    logic [7:0]  spr_addr;
    logic [7:0]  spr_wdata;
    logic        active;
    logic        done;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] spr_mem [256];
    logic [7:0] cur_page = 8'h00;
    bit cur_ok = 0;
    int tk = 0, idx = 0, n_writes = 0, n_done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) phase <= phase + 2'd1;
    assign mcyc_en = (phase == 2'd3);

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return (a[15:8] * 8'd3) ^ a[7:0] ^ 8'hA5;
    endfunction
    assign rd_data = mem_model(src_addr);

    spr_dma_engine #(.XFER_LEN(LEN), .START_DELAY_MC(START)) uut (
        .clk(clk), .rst_n(rst_n), .mcyc_en(mcyc_en), .trig_wr(trig_wr),
        .trig_page(trig_page), .rd_en(rd_en), .src_addr(src_addr),
        .rd_data(rd_data), .spr_we(spr_we), .spr_addr(spr_addr),
        .spr_wdata(spr_wdata), .active(active), .done(done));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: sample at the falling edge, compare against the arithmetic model
    task automatic clk_step();
        bit exp_we;
        bit exp_act;
        @(negedge clk);
        exp_we = 0;
        exp_act = cur_ok && (idx < LEN);
        if (mcyc_en) begin
            tk++;
            exp_we = cur_ok && (tk >= START) && (idx < LEN);
        end
        chk(active == exp_act, "R7 active level", active, exp_act);
        chk(spr_we == exp_we, !mcyc_en ? "R9 write off tick" : (cur_ok ? "R3 write timing" : "R2 ignored trigger"), spr_we, exp_we);
        chk(rd_en == exp_we, "R4 read strobe", rd_en, exp_we);
        if (exp_we && spr_we) begin
            chk(spr_addr == idx[7:0], "R5 destination order", spr_addr, idx);
            chk(src_addr == {cur_page, idx[7:0]}, "R4 source address", src_addr, {cur_page, idx[7:0]});
            chk(spr_wdata == mem_model(src_addr), "R4 data copied", spr_wdata, mem_model(src_addr));
            chk(done == (idx == LEN - 1), "R8 done on last byte", done, (idx == LEN - 1));
        end else begin
            chk(done == 1'b0, "R8 done quiet", done, 0);
        end
        if (spr_we) begin
            spr_mem[spr_addr] = spr_wdata;
            n_writes++;
        end
        if (done) n_done++;
        if (exp_we) idx++;
    endtask

    task automatic trigger(input logic [7:0] page);
        if (mcyc_en) clk_step();
        trig_wr = 1'b1;
        trig_page = page;
        if (page <= 8'hF1) begin
            cur_page = page;
            cur_ok = 1;
            tk = 0;
            idx = 0;
        end
        clk_step();
        trig_wr = 1'b0;
        if (page <= 8'hF1)
            chk(src_addr == {page, 8'h00}, "R1 source loaded", src_addr, {page, 8'h00});
    endtask

    task automatic run_out();
        repeat ((START + LEN + 2) * 4) clk_step();
    endtask

    task automatic check_mem(input logic [7:0] page, input string req);
        for (int i = 0; i < LEN; i++)
            chk(spr_mem[i] == mem_model({page, i[7:0]}), req, spr_mem[i], mem_model({page, i[7:0]}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w0, d0;
        for (int i = 0; i < 256; i++) spr_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(active == 1'b0, "R7 reset active", active, 0);
        chk(spr_we == 1'b0, "R9 reset write", spr_we, 0);
        chk(done == 1'b0, "R8 reset done", done, 0);
        rst_n = 1'b1;

        // sweep every page: accepted ones copy, rejected ones do nothing
        for (int p = 0; p < 256; p++) begin
            w0 = n_writes;
            d0 = n_done;
            trigger(8'(p));
            run_out();
            if (p <= 'hF1) begin
                chk(n_writes - w0 == LEN, "R5 byte count", n_writes - w0, LEN);
                chk(n_done - d0 == 1, "R8 one done", n_done - d0, 1);
                check_mem(8'(p), "R5 sprite contents");
            end else begin
                chk(n_writes - w0 == 0, "R2 rejected page writes", n_writes - w0, 0);
                chk(active == 1'b0, "R2 rejected page idle", active, 0);
            end
        end

        // restart in mid-copy
        w0 = n_writes;
        d0 = n_done;
        trigger(8'h12);
        while (idx < 5) clk_step();
        trigger(8'h34);
        run_out();
        chk(n_writes - w0 == 5 + LEN, "R6 restart write count", n_writes - w0, 5 + LEN);
        chk(n_done - d0 == 1, "R6 restart single done", n_done - d0, 1);
        check_mem(8'h34, "R6 restart contents");

        // rejected trigger during a copy leaves it running
        w0 = n_writes;
        d0 = n_done;
        trigger(8'h40);
        while (idx < 3) clk_step();
        trigger(8'hF5);
        run_out();
        chk(n_writes - w0 == LEN, "R2 copy continues count", n_writes - w0, LEN);
        chk(n_done - d0 == 1, "R2 copy continues done", n_done - d0, 1);
        check_mem(8'h40, "R2 copy continues contents");

        // restart during the warm-up window
        trigger(8'h55);
        clk_step();
        trigger(8'h66);
        run_out();
        check_mem(8'h66, "R6 warm-up restart contents");

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule